// File: doc/BRIEF.md
# VCO Band Auto-Calibration Controller

This block picks one of four oscillator cores and a 6-bit coarse capacitor code so that the open-loop tuning voltage of the synthesizer lands near its calibration reference. It runs a bounded successive-approximation search. Each trial setting is applied to the oscillator, given one calibration tick to settle, and then judged from a short burst of comparator samples that report whether the oscillator runs too fast. The search first decides the core index, with the capacitor code parked at mid-scale, and then decides the capacitor code from its most significant bit down.

The block has three ways of running. A full search decides both the core and the capacitor code. A single-core search takes the core from a manual input and searches only the capacitor code. A bypass mode applies the manual core and capacitor values directly and runs no search. The pace of the search comes from a calibration tick derived from the reference clock through a 4-bit scale code. A 2-bit accuracy code sets how many contrary comparator samples a decision tolerates. The last result is held for readback. A sticky flag records any reference-divider saturation seen while a search runs. The block carries no data stream: every pin is a plain level or a single-cycle pulse, and there is no back-pressure.

Top module: `vcocal_ctrl`

## Requirements
- R1: With base period B system clocks per reference cycle (parameter `BASE_PERIOD`), the calibration tick period for scale code c is B<<c[2:0] when c[3]=1. When c[3]=0 it is B>>(7-c[2:0]), floored at 1 clock. Code 0111 therefore gives B. The code is captured at the start of a search.
- R2: In full search, busy lasts exactly 46 tick periods.
- R3: In single-core search, busy lasts exactly 34 tick periods. The core output equals the manual core value captured at start for the whole search and in the result.
- R4: While bypass is set and no search runs, the core and capacitor outputs equal the manual inputs one clock after they are applied. A start pulse then launches nothing: busy and done stay low.
- R5: A one-clock start pulse launches a search. A start pulse during a search is ignored, as are changes to the scale, accuracy and mode inputs during a search.
- R6: The readback outputs change only in the clock where done is high, and they then hold the search result. When idle with bypass clear, the applied outputs show the readback values.
- R7: Each decision uses 4 comparator samples and is "too fast" when the count of high samples exceeds a tolerance. The tolerance is 0 for accuracy code 00, 3 for 01, 2 for 10 and 1 for 11.
- R8: The saturation flag sets one clock after the saturation input is seen high during a search. It holds through done and while idle, ignores the saturation input while idle, and clears when the next search launches.
- R9: Done is high for exactly one clock, in the first clock after busy falls.
- R10: The comparator strobe pulses exactly 4 times per decided bit (32 per full search, 24 per single-core search) and only while busy.
- R11: For a core bit, a "too fast" verdict clears the trial bit. For a capacitor bit, a "too fast" verdict keeps the trial bit; a higher code means a lower frequency. The capacitor code is 32 while cores are searched.
- R12: After reset, busy, done, strobe and the saturation flag are 0, and the core, capacitor and readback outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the reference clock domain |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_start | input | 1 | One-clock pulse that launches a search |
| single_vco_mode | input | 1 | 1: search capacitor code only, core from `vco_manual` |
| bypass_en | input | 1 | 1: apply manual values, no search |
| vco_manual | input | VCO_W | Manual core index |
| trim_manual | input | TRIM_W | Manual capacitor code |
| clk_scale | input | 4 | Calibration tick scale code |
| accuracy | input | 2 | Decision tolerance code |
| cmp_high | input | 1 | Comparator: 1 = oscillator too fast |
| rdiv_sat | input | 1 | Reference-divider saturation indication |
| vco_sel | output | VCO_W | Applied core index (trial value during a search) |
| trim_code | output | TRIM_W | Applied capacitor code (trial value during a search) |
| rb_vco | output | VCO_W | Readback of the last search's core |
| rb_trim | output | TRIM_W | Readback of the last search's capacitor code |
| cal_busy | output | 1 | Search in progress |
| cal_done | output | 1 | One-clock pulse when the result is latched |
| sat_error | output | 1 | Sticky saturation flag |
| cmp_strobe | output | 1 | Comparator is sampled at the coming clock edge |

## Verification
A search launched at edge e0 keeps busy high for exactly N×P clocks (N = 46 or 34, P the tick period). Done, readback and the final outputs are due in the clock after the last of those. The bench therefore counts busy clocks on falling edges and checks results on the falling edge where done is first seen, then checks one clock later that done has dropped. Comparator stimulus is set on the falling edge where the strobe is visible, so that it is stable for the sampling edge. Bypass and saturation effects are due one clock after the stimulus and are sampled on the next falling edge.

// File: rtl/vcocal_pkg.sv
package vcocal_pkg;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_INIT,
    CS_SETTLE,
    CS_SAMPLE,
    CS_HAND,
    CS_FINISH
  } cal_state_e;

  localparam int unsigned SCALE_FIELD_W  = 4;
  localparam int unsigned SCALE_MAX_SHIFT = 7;

  // Contrary samples a decision may contain; larger code = tighter, zero code = none.
  function automatic int unsigned err_tolerance(input logic [1:0] acc, input int unsigned samples);
    if (acc == 2'd0) return 0;
    return samples - 32'(acc);
  endfunction

endpackage

// File: rtl/vcocal_tick_gen.sv
module vcocal_tick_gen
  import vcocal_pkg::*;
#(
  parameter int unsigned BASE_PERIOD = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     restart,
  input  logic [SCALE_FIELD_W-1:0] scale_code,
  output logic                     tick
);
  localparam int unsigned MAX_PERIOD = BASE_PERIOD << SCALE_MAX_SHIFT;
  localparam int unsigned CNT_W      = $clog2(MAX_PERIOD + 1);
  localparam int unsigned SH_W       = SCALE_FIELD_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] period;
  logic [SH_W-1:0]  shamt;

  always_comb begin
    if (scale_code[SCALE_FIELD_W-1]) begin
      shamt  = scale_code[SH_W-1:0];
      period = CNT_W'(BASE_PERIOD) << shamt;
    end else begin
      shamt  = SH_W'(SCALE_MAX_SHIFT) - scale_code[SH_W-1:0];
      period = CNT_W'(BASE_PERIOD) >> shamt;
    end
    if (period == '0) period = CNT_W'(1);
  end

  assign tick = (cnt_q == period - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart || tick) cnt_q <= '0;
    else                      cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/vcocal_vote.sv
module vcocal_vote
  import vcocal_pkg::*;
#(
  parameter int unsigned SAMPLES = 4   // must be at least 4 for the tolerance codes
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_en,
  input  logic       last_sample,
  input  logic       cmp_high,
  input  logic [1:0] acc_code,
  output logic       verdict_high
);
  localparam int unsigned CW = $clog2(SAMPLES + 1);

  logic [CW-1:0] hits_q;
  logic [CW-1:0] hits_now;

  assign hits_now     = hits_q + CW'(cmp_high);
  assign verdict_high = (32'(hits_now) > err_tolerance(acc_code, SAMPLES));

  always_ff @(posedge clk) begin
    if (!rst_n)         hits_q <= '0;
    else if (sample_en) hits_q <= last_sample ? '0 : hits_now;
  end

endmodule

// File: rtl/vcocal_sar.sv
module vcocal_sar
  import vcocal_pkg::*;
#(
  parameter int unsigned VCO_W        = 2,
  parameter int unsigned TRIM_W       = 6,
  parameter int unsigned SAMPLES      = 4,
  parameter int unsigned HAND_TICKS   = 2,
  parameter int unsigned FINISH_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              tick,
  input  logic              full_search,
  input  logic [VCO_W-1:0]  vco_fixed,
  input  logic              verdict_high,
  output logic              active,
  output logic              sampling,
  output logic              last_sample,
  output logic              finish_now,
  output logic [VCO_W-1:0]  vco_try,
  output logic [TRIM_W-1:0] trim_try
);
  localparam int unsigned SUB_MAX0 = (SAMPLES > HAND_TICKS) ? SAMPLES : HAND_TICKS;
  localparam int unsigned SUB_MAX  = (SUB_MAX0 > FINISH_TICKS) ? SUB_MAX0 : FINISH_TICKS;
  localparam int unsigned SUB_W    = $clog2(SUB_MAX + 1);
  localparam logic [VCO_W-1:0]  VCO_MSB  = VCO_W'(1) << (VCO_W - 1);
  localparam logic [TRIM_W-1:0] TRIM_MSB = TRIM_W'(1) << (TRIM_W - 1);

  cal_state_e        state_q;
  logic [SUB_W-1:0]  sub_q;
  logic              in_vco_q;
  logic [VCO_W-1:0]  vco_bit_q;
  logic [TRIM_W-1:0] trim_bit_q;
  logic [VCO_W-1:0]  vco_try_q;
  logic [TRIM_W-1:0] trim_try_q;

  logic sub_end_sample, sub_end_hand, sub_end_finish;
  assign sub_end_sample = (sub_q == SUB_W'(SAMPLES - 1));
  assign sub_end_hand   = (sub_q == SUB_W'(HAND_TICKS - 1));
  assign sub_end_finish = (sub_q == SUB_W'(FINISH_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= CS_IDLE;
      sub_q      <= '0;
      in_vco_q   <= 1'b0;
      vco_bit_q  <= '0;
      trim_bit_q <= '0;
      vco_try_q  <= '0;
      trim_try_q <= '0;
    end else if (launch) begin
      state_q    <= CS_INIT;
      sub_q      <= '0;
      in_vco_q   <= full_search;
      vco_bit_q  <= VCO_MSB;
      trim_bit_q <= TRIM_MSB;
      vco_try_q  <= full_search ? VCO_MSB : vco_fixed;
      trim_try_q <= TRIM_MSB;
    end else if (tick) begin
      unique case (state_q)
        CS_INIT: state_q <= CS_SETTLE;
        CS_SETTLE: begin
          state_q <= CS_SAMPLE;
          sub_q   <= '0;
        end
        CS_SAMPLE: begin
          if (!sub_end_sample) begin
            sub_q <= sub_q + SUB_W'(1);
          end else begin
            sub_q <= '0;
            if (in_vco_q) begin
              // too fast: drop the core bit; then trial the next lower bit
              vco_try_q <= (verdict_high ? (vco_try_q & ~vco_bit_q) : vco_try_q) | (vco_bit_q >> 1);
              vco_bit_q <= vco_bit_q >> 1;
              if (vco_bit_q[0]) begin
                in_vco_q <= 1'b0;
                state_q  <= CS_HAND;
              end else begin
                state_q  <= CS_SETTLE;
              end
            end else begin
              // too fast: keep capacitance; too slow: drop it
              trim_try_q <= (verdict_high ? trim_try_q : (trim_try_q & ~trim_bit_q)) | (trim_bit_q >> 1);
              trim_bit_q <= trim_bit_q >> 1;
              state_q    <= trim_bit_q[0] ? CS_FINISH : CS_SETTLE;
            end
          end
        end
        CS_HAND: begin
          if (sub_end_hand) begin
            state_q <= CS_SETTLE;
            sub_q   <= '0;
          end else begin
            sub_q <= sub_q + SUB_W'(1);
          end
        end
        CS_FINISH: begin
          if (sub_end_finish) begin
            state_q <= CS_IDLE;
            sub_q   <= '0;
          end else begin
            sub_q <= sub_q + SUB_W'(1);
          end
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end

  assign active      = (state_q != CS_IDLE);
  assign sampling    = (state_q == CS_SAMPLE);
  assign last_sample = sampling && sub_end_sample;
  assign finish_now  = tick && (state_q == CS_FINISH) && sub_end_finish;
  assign vco_try     = vco_try_q;
  assign trim_try    = trim_try_q;

endmodule

// File: rtl/vcocal_ctrl.sv
module vcocal_ctrl
  import vcocal_pkg::*;
#(
  parameter int unsigned BASE_PERIOD = 16,
  parameter int unsigned VCO_W       = 2,
  parameter int unsigned TRIM_W      = 6,
  parameter int unsigned SAMPLES     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_start,
  input  logic              single_vco_mode,
  input  logic              bypass_en,
  input  logic [VCO_W-1:0]  vco_manual,
  input  logic [TRIM_W-1:0] trim_manual,
  input  logic [3:0]        clk_scale,
  input  logic [1:0]        accuracy,
  input  logic              cmp_high,
  input  logic              rdiv_sat,
  output logic [VCO_W-1:0]  vco_sel,
  output logic [TRIM_W-1:0] trim_code,
  output logic [VCO_W-1:0]  rb_vco,
  output logic [TRIM_W-1:0] rb_trim,
  output logic              cal_busy,
  output logic              cal_done,
  output logic              sat_error,
  output logic              cmp_strobe
);
  localparam int unsigned HAND_TICKS   = 2;
  localparam int unsigned FINISH_TICKS = 3;
  localparam logic [SCALE_FIELD_W-1:0] SCALE_UNITY = SCALE_FIELD_W'(1) << (SCALE_FIELD_W - 1);

  logic                     active, sampling, last_sample, finish_now, tick, verdict_high, launch;
  logic [VCO_W-1:0]         vco_try;
  logic [TRIM_W-1:0]        trim_try;
  logic [SCALE_FIELD_W-1:0] scale_q;
  logic [1:0]               acc_q;
  logic                     byp_q, done_q, sat_q;
  logic [VCO_W-1:0]         man_vco_q, rb_vco_q;
  logic [TRIM_W-1:0]        man_trim_q, rb_trim_q;

  assign launch = cal_start && !active && !bypass_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_q <= SCALE_UNITY;
      acc_q   <= '0;
    end else if (launch) begin
      scale_q <= clk_scale;
      acc_q   <= accuracy;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp_q      <= 1'b0;
      man_vco_q  <= '0;
      man_trim_q <= '0;
    end else if (!active) begin
      byp_q      <= bypass_en;
      man_vco_q  <= vco_manual;
      man_trim_q <= trim_manual;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_vco_q  <= '0;
      rb_trim_q <= '0;
      done_q    <= 1'b0;
      sat_q     <= 1'b0;
    end else begin
      done_q <= finish_now;
      if (finish_now) begin
        rb_vco_q  <= vco_try;
        rb_trim_q <= trim_try;
      end
      if (launch)                sat_q <= 1'b0;
      else if (active && rdiv_sat) sat_q <= 1'b1;
    end
  end

  vcocal_tick_gen #(
    .BASE_PERIOD(BASE_PERIOD)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (launch),
    .scale_code(scale_q),
    .tick      (tick)
  );

  vcocal_vote #(
    .SAMPLES(SAMPLES)
  ) u_vote (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en   (cmp_strobe),
    .last_sample (last_sample),
    .cmp_high    (cmp_high),
    .acc_code    (acc_q),
    .verdict_high(verdict_high)
  );

  vcocal_sar #(
    .VCO_W       (VCO_W),
    .TRIM_W      (TRIM_W),
    .SAMPLES     (SAMPLES),
    .HAND_TICKS  (HAND_TICKS),
    .FINISH_TICKS(FINISH_TICKS)
  ) u_sar (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .tick        (tick),
    .full_search (!single_vco_mode),
    .vco_fixed   (vco_manual),
    .verdict_high(verdict_high),
    .active      (active),
    .sampling    (sampling),
    .last_sample (last_sample),
    .finish_now  (finish_now),
    .vco_try     (vco_try),
    .trim_try    (trim_try)
  );

  assign cmp_strobe = sampling && tick;
  assign cal_busy   = active;
  assign cal_done   = done_q;
  assign sat_error  = sat_q;
  assign rb_vco     = rb_vco_q;
  assign rb_trim    = rb_trim_q;
  assign vco_sel    = active ? vco_try  : (byp_q ? man_vco_q  : rb_vco_q);
  assign trim_code  = active ? trim_try : (byp_q ? man_trim_q : rb_trim_q);

endmodule

// File: rtl/vcocal_ctrl_chk.sv
module vcocal_ctrl_chk #(
  parameter int unsigned VCO_W  = 2,
  parameter int unsigned TRIM_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cal_start,
  input logic              bypass_en,
  input logic [VCO_W-1:0]  vco_manual,
  input logic [TRIM_W-1:0] trim_manual,
  input logic              rdiv_sat,
  input logic [VCO_W-1:0]  vco_sel,
  input logic [TRIM_W-1:0] trim_code,
  input logic [VCO_W-1:0]  rb_vco,
  input logic [TRIM_W-1:0] rb_trim,
  input logic              cal_busy,
  input logic              cal_done,
  input logic              sat_error,
  input logic              cmp_strobe
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> !cal_done); // R9

  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cal_done) |-> ($past(cal_busy) && !cal_busy)); // R9

  AST_STROBE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |-> cal_busy); // R10

  AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(bypass_en) && !$past(cal_busy) && !cal_busy)
      |-> (vco_sel == $past(vco_manual) && trim_code == $past(trim_manual))); // R4

  AST_BYPASS_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(bypass_en) && !$past(cal_busy)) |-> !cal_busy); // R4

  AST_SAT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cal_busy) && $past(rdiv_sat)) |-> sat_error); // R8

  AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(sat_error) && !$past(cal_start)) |-> sat_error); // R8

  AST_RB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cal_done) |-> ($stable(rb_vco) && $stable(rb_trim))); // R6

endmodule

bind vcocal_ctrl vcocal_ctrl_chk #(
  .VCO_W (VCO_W),
  .TRIM_W(TRIM_W)
) u_vcocal_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cal_start  (cal_start),
  .bypass_en  (bypass_en),
  .vco_manual (vco_manual),
  .trim_manual(trim_manual),
  .rdiv_sat   (rdiv_sat),
  .vco_sel    (vco_sel),
  .trim_code  (trim_code),
  .rb_vco     (rb_vco),
  .rb_trim    (rb_trim),
  .cal_busy   (cal_busy),
  .cal_done   (cal_done),
  .sat_error  (sat_error),
  .cmp_strobe (cmp_strobe)
);

// File: tb/tb_vcocal_ctrl.sv
module tb_vcocal_ctrl;
  localparam int BASE = 4;
  localparam int VW = 2;
  localparam int TW = 6;
  localparam int NS = 4;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cal_start = 0, single_vco_mode = 0, bypass_en = 0, rdiv_sat = 0;
  logic [VW-1:0] vco_manual = '0;
  logic [TW-1:0] trim_manual = '0;
  logic [3:0]    clk_scale = '0;
  logic [1:0]    accuracy = '0;
  logic          cmp_high;
  logic [VW-1:0] vco_sel, rb_vco;
  logic [TW-1:0] trim_code, rb_trim;
  logic          cal_busy, cal_done, sat_error, cmp_strobe;

  vcocal_ctrl #(.BASE_PERIOD(BASE), .VCO_W(VW), .TRIM_W(TW), .SAMPLES(NS)) dut (
    .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .single_vco_mode(single_vco_mode),
    .bypass_en(bypass_en), .vco_manual(vco_manual), .trim_manual(trim_manual),
    .clk_scale(clk_scale), .accuracy(accuracy), .cmp_high(cmp_high), .rdiv_sat(rdiv_sat),
    .vco_sel(vco_sel), .trim_code(trim_code), .rb_vco(rb_vco), .rb_trim(rb_trim),
    .cal_busy(cal_busy), .cal_done(cal_done), .sat_error(sat_error), .cmp_strobe(cmp_strobe));

  int checks = 0, failures = 0, cyc = 0;
  int target = 0, pat_h = 0, pat_idx = 0;
  bit use_pat = 0;
  logic pat_val = 0;
  logic model_val;
  int busy_len = 0, strobes = 0;

  // Oscillator model: frequency rank rises with core, falls with capacitor code.
  assign model_val = ((int'(vco_sel) * 64 + 63 - int'(trim_code)) > target);
  assign cmp_high  = use_pat ? pat_val : model_val;

  always @(negedge clk) begin
    if (cmp_strobe) begin
      pat_val = ((pat_idx % NS) < pat_h);
      pat_idx++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT) begin
      checks++;
      failures++;
      $display("FAIL watchdog R9 actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input logic [3:0] c);
    int p;
    if (c[3]) return BASE << c[2:0];
    p = BASE >> (7 - int'(c[2:0]));
    return (p < 1) ? 1 : p;
  endfunction

  function automatic int exp_vco(input int t);
    int r = 0;
    for (int v = 0; v < 4; v++) if (v * 64 + 31 <= t) r = v;
    return r;
  endfunction

  function automatic int exp_trim(input int v, input int t);
    int x = v * 64 + 62 - t;
    if (x < 0) x = 0;
    if (x > 63) x = 63;
    return x;
  endfunction

  function automatic int tol_of(input int acc);
    case (acc)
      0: return 0;
      1: return 3;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic run_cal(input bit single, input int vman, input int sc, input int acc,
                         input int restart_at, input int sat_at);
    @(negedge clk);
    single_vco_mode = single;
    vco_manual = VW'(vman);
    clk_scale = 4'(sc);
    accuracy = 2'(acc);
    pat_idx = 0;
    cal_start = 1;
    @(negedge clk);
    cal_start = 0;
    busy_len = 0;
    strobes = 0;
    while (!cal_done) begin
      if (cal_busy) busy_len++;
      if (cmp_strobe) strobes++;
      cal_start = (busy_len == restart_at);
      rdiv_sat = (busy_len == sat_at);
      if (busy_len == restart_at) begin
        clk_scale = 4'b1111;
        accuracy = 2'b01;
        single_vco_mode = ~single;
      end
      @(negedge clk);
    end
    cal_start = 0;
    rdiv_sat = 0;
  endtask

  task automatic done_drop;
    @(negedge clk);
    chk(cal_done == 0 && cal_busy == 0, "R9 done one cycle", int'(cal_done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(cal_busy == 0 && cal_done == 0 && cmp_strobe == 0, "R12 idle flags", int'(cal_busy), 0);
    chk(sat_error == 0, "R12 sat flag", int'(sat_error), 0);
    chk(vco_sel == 0 && trim_code == 0, "R12 applied outputs", int'(trim_code), 0);
    chk(rb_vco == 0 && rb_trim == 0, "R12 readback", int'(rb_trim), 0);

    // R2 / R11 / R10 / R6: exhaustive target sweep, full search
    for (int t = 0; t < 256; t++) begin
      target = t;
      run_cal(0, 0, 0, 0, -1, -1);
      chk(busy_len == 46, "R2 full busy length", busy_len, 46);
      chk(strobes == 32, "R10 full strobes", strobes, 32);
      chk(int'(vco_sel) == exp_vco(t), "R11 core result", int'(vco_sel), exp_vco(t));
      chk(int'(trim_code) == exp_trim(exp_vco(t), t), "R11 capacitor result",
          int'(trim_code), exp_trim(exp_vco(t), t));
      chk(int'(rb_vco) == exp_vco(t) && int'(rb_trim) == exp_trim(exp_vco(t), t),
          "R6 readback", int'(rb_trim), exp_trim(exp_vco(t), t));
      done_drop();
    end

    // R3 / R10: single-core search
    for (int v = 0; v < 4; v++) begin
      for (int t = 0; t < 256; t += 5) begin
        target = t;
        run_cal(1, v, 0, 0, -1, -1);
        chk(busy_len == 34, "R3 single busy length", busy_len, 34);
        chk(strobes == 24, "R10 single strobes", strobes, 24);
        chk(int'(vco_sel) == v, "R3 core fixed", int'(vco_sel), v);
        chk(int'(trim_code) == exp_trim(v, t), "R3 capacitor result", int'(trim_code), exp_trim(v, t));
      end
    end

    // R1: every scale code
    target = 100;
    for (int c = 0; c < 16; c++) begin
      run_cal(1, 2, c, 0, -1, -1);
      chk(busy_len == 34 * period_of(4'(c)), "R1 tick period", busy_len, 34 * period_of(4'(c)));
    end

    // R7: accuracy tolerance vs number of high samples
    use_pat = 1;
    for (int a = 0; a < 4; a++) begin
      for (int h = 0; h <= NS; h++) begin
        pat_h = h;
        run_cal(1, 1, 0, a, -1, -1);
        chk(int'(trim_code) == ((h > tol_of(a)) ? 63 : 0), "R7 tolerance",
            int'(trim_code), (h > tol_of(a)) ? 63 : 0);
      end
    end
    pat_h = 1;
    run_cal(0, 0, 0, 0, -1, -1);
    chk(int'(vco_sel) == 0 && int'(trim_code) == 63, "R7 full search all fast", int'(vco_sel), 0);
    use_pat = 0;

    // R5: restart and input changes during a search are ignored (scale 1000 => BASE)
    target = 100;
    run_cal(1, 2, 8, 0, 20, -1);
    chk(busy_len == 34 * BASE, "R5 start ignored while busy", busy_len, 34 * BASE);
    chk(int'(vco_sel) == 2 && int'(trim_code) == exp_trim(2, 100), "R5 result unchanged",
        int'(trim_code), exp_trim(2, 100));

    // R8: saturation flag
    @(negedge clk);
    rdiv_sat = 1;
    @(negedge clk);
    rdiv_sat = 0;
    @(negedge clk);
    chk(sat_error == 0, "R8 idle saturation ignored", int'(sat_error), 0);
    run_cal(1, 2, 0, 0, -1, 10);
    chk(sat_error == 1, "R8 saturation captured", int'(sat_error), 1);
    repeat (3) @(negedge clk);
    chk(sat_error == 1, "R8 saturation held idle", int'(sat_error), 1);
    run_cal(1, 2, 0, 0, -1, -1);
    chk(sat_error == 0, "R8 cleared by new search", int'(sat_error), 0);

    // R4 / R6: bypass
    @(negedge clk);
    bypass_en = 1;
    vco_manual = 2'd3;
    trim_manual = 6'd17;
    @(negedge clk);
    chk(vco_sel == 3 && trim_code == 17, "R4 bypass applies manual", int'(trim_code), 17);
    cal_start = 1;
    @(negedge clk);
    cal_start = 0;
    for (int i = 0; i < 5; i++) begin
      chk(cal_busy == 0 && cal_done == 0, "R4 start ignored in bypass", int'(cal_busy), 0);
      @(negedge clk);
    end
    trim_manual = 6'd50;
    @(negedge clk);
    chk(trim_code == 50, "R4 bypass tracks change", int'(trim_code), 50);
    chk(int'(rb_vco) == 2 && int'(rb_trim) == exp_trim(2, 100), "R6 readback held in bypass",
        int'(rb_trim), exp_trim(2, 100));
    bypass_en = 0;
    @(negedge clk);
    chk(vco_sel == rb_vco && trim_code == rb_trim, "R6 outputs return to readback",
        int'(trim_code), int'(rb_trim));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule